// File: doc/BRIEF.md
# Bus-Cycle Break Comparator

This block watches the bus cycles issued by the processor core or by a DMA master and raises a break interrupt when one of them meets a programmed set of conditions. The address and data of a cycle are compared bit by bit against programmed values, and a mask sets any bit to don't-care. Four two-bit qualifiers filter on who issued the cycle, whether it fetches an instruction or moves data, its direction, and its width. The all-zero code of each qualifier means "any".

A bus cycle is presented as an address phase, marked by `bus_start` together with the address and the cycle attributes, and a completion, marked by `bus_end` together with the data. Both strobes may fall in the same clock for a zero-wait cycle. The address and attribute comparison is done and held at the start of the cycle. The data comparison is done at completion and applies only to data accesses. A match sets a sticky status flag one clock after the completing cycle. The flag stays set until software writes a one to clear it. The interrupt output shows the flag whenever the interrupt enable is set.

Software programs the conditions through a simple write port. The register offsets (3-bit `cfg_addr`) are:

| Offset | Contents |
|---|---|
| 0 | address compare value |
| 1 | address mask (1 = don't-care) |
| 2 | data compare value |
| 3 | data mask (1 = don't-care) |
| 4 | control |
| 5 | status; writing 1 to bit 0 clears the flag |

The control register holds:

| Bits | Field |
|---|---|
| [1:0] | master qualifier |
| [3:2] | access-kind qualifier |
| [5:4] | direction qualifier |
| [7:6] | size qualifier |
| 8 | interrupt enable |

Top module: `bus_break_unit`

## Requirements
- R1: The address condition holds when `((bus_addr ^ address compare) & ~address mask) == 0`, with the address taken in the `bus_start` clock.
- R2: Master qualifier (control [1:0]): 01 accepts only cycles with `bus_cpu`=1, 10 accepts only `bus_cpu`=0, and 00 or 11 accept both.
- R3: Access-kind qualifier (control [3:2]): 01 accepts only instruction fetches (`bus_fetch`=1), 10 accepts only data accesses, and 00 or 11 accept both.
- R4: Direction qualifier (control [5:4]): 01 accepts only reads (`bus_write`=0), 10 accepts only writes, and 00 or 11 accept both.
- R5: Size qualifier (control [7:6]): 00 accepts any size, and 01, 10 and 11 accept only `bus_size` 00 (byte), 01 (word) and 10 (longword) respectively.
- R6: For a data access the condition `((bus_data ^ data compare) & ~data mask) == 0` must also hold, with the data taken in the `bus_end` clock. For an instruction fetch the data value never affects the match.
- R7: When a cycle meets every condition, `brk_flag` is 0 during the `bus_end` clock and reads 1 from the next clock on. This holds for zero-wait cycles and for cycles with wait states.
- R8: The flag stays set until a write to offset 5 with bit 0 = 1. A write with bit 0 = 0 leaves it set. A matching completion in the same clock as a clear leaves the flag set.
- R9: `brk_irq` equals `brk_flag` while control bit 8 is 1 and is 0 while it is 0. Changing the enable does not alter the flag.
- R10: After reset the flag and interrupt are 0 and every register is zero. A data cycle at address 0 with data 0 then matches, and any other address does not.
- R11: Address and attributes presented between `bus_start` and `bus_end` of a multi-clock cycle have no effect on that cycle's match.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | synchronous active-low reset |
| cfg_we | input | 1 | register write strobe |
| cfg_addr | input | 3 | register offset |
| cfg_wdata | input | 32 | register write data |
| bus_start | input | 1 | address phase of a monitored cycle |
| bus_end | input | 1 | completion of the monitored cycle |
| bus_addr | input | 32 | cycle address, valid with `bus_start` |
| bus_cpu | input | 1 | 1 = cycle issued by the processor core, 0 = by another master |
| bus_fetch | input | 1 | 1 = instruction fetch, 0 = data access |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_size | input | 2 | 00 byte, 01 word, 10 longword |
| bus_data | input | 32 | cycle data, valid with `bus_end` |
| brk_flag | output | 1 | sticky break status |
| brk_irq | output | 1 | break interrupt request |

## Verification
The bench sweeps all 256 qualifier settings against every combination of master, kind, direction and size. A wrong decode or a swapped field would set the flag where the arithmetic model says it must not, or miss a hit. It walks a single mask bit through the address and data words, so an off-by-one mask would match on an unmasked bit. It also sends fetches with wrong data, which a design that compares data on fetches would reject. Multi-clock cycles are sent with the address and attributes scrambled after the start, which exposes a design that samples late. Clear-versus-hit collisions and enable toggling catch a flag that clears too eagerly or an interrupt that ignores the enable.

// File: rtl/brk_pkg.sv
// Shared types and helpers for the bus-cycle break comparator.
// Assumes a 3-bit register offset space and fixed control field layout.
package brk_pkg;

    localparam int CFG_AW = 3;

    typedef enum logic [CFG_AW-1:0] {
        REG_ACMP = 3'd0,
        REG_AMSK = 3'd1,
        REG_DCMP = 3'd2,
        REG_DMSK = 3'd3,
        REG_CTRL = 3'd4,
        REG_STAT = 3'd5
    } brk_reg_e;

    // Qualifier byte, packed so that master sits in bits [1:0].
    typedef struct packed {
        logic [1:0] size;
        logic [1:0] dir;
        logic [1:0] kind;
        logic [1:0] master;
    } qual_t;

    localparam int QUAL_W = $bits(qual_t);
    localparam int IEN_BIT = QUAL_W;

    // Two-option qualifier: code bit 0 admits the first option, bit 1 the second,
    // code 00 admits both.
    function automatic logic pair_ok(input logic [1:0] code, input logic first_opt);
        return (code == 2'b00) || (code[0] && first_opt) || (code[1] && !first_opt);
    endfunction

    // Size qualifier: 00 any, otherwise code-1 must equal the bus size code.
    function automatic logic size_ok(input logic [1:0] code, input logic [1:0] sz);
        return (code == 2'b00) || ((code - 2'd1) == sz);
    endfunction

endpackage

// File: rtl/brk_cfg_regs.sv
// Condition register file of the break comparator.
// Holds compare values, masks, qualifiers and the interrupt enable; turns a
// write of one to the status offset into a single-clock clear request.
// Assumes REG_W >= ADDR_W, DATA_W and >= 9.
module brk_cfg_regs
    import brk_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    parameter int REG_W  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [CFG_AW-1:0] cfg_addr,
    input  logic [REG_W-1:0]  cfg_wdata,
    output logic [ADDR_W-1:0] acmp,
    output logic [ADDR_W-1:0] amsk,
    output logic [DATA_W-1:0] dcmp,
    output logic [DATA_W-1:0] dmsk,
    output qual_t             qual,
    output logic              ien,
    output logic              clr_req
);

    logic hit_acmp, hit_amsk, hit_dcmp, hit_dmsk, hit_ctrl, hit_stat;

    // Offset decode for the write port.
    always_comb begin
        hit_acmp = cfg_we && (cfg_addr == REG_ACMP);
        hit_amsk = cfg_we && (cfg_addr == REG_AMSK);
        hit_dcmp = cfg_we && (cfg_addr == REG_DCMP);
        hit_dmsk = cfg_we && (cfg_addr == REG_DMSK);
        hit_ctrl = cfg_we && (cfg_addr == REG_CTRL);
        hit_stat = cfg_we && (cfg_addr == REG_STAT);
    end

    // Address compare value and mask.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acmp <= '0;
            amsk <= '0;
        end else begin
            if (hit_acmp) acmp <= cfg_wdata[ADDR_W-1:0];
            if (hit_amsk) amsk <= cfg_wdata[ADDR_W-1:0];
        end
    end

    // Data compare value and mask.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dcmp <= '0;
            dmsk <= '0;
        end else begin
            if (hit_dcmp) dcmp <= cfg_wdata[DATA_W-1:0];
            if (hit_dmsk) dmsk <= cfg_wdata[DATA_W-1:0];
        end
    end

    // Qualifier byte and interrupt enable.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            qual <= '0;
            ien  <= 1'b0;
        end else if (hit_ctrl) begin
            qual <= qual_t'(cfg_wdata[QUAL_W-1:0]);
            ien  <= cfg_wdata[IEN_BIT];
        end
    end

    // Clear request, valid in the write clock only.
    always_comb clr_req = hit_stat && cfg_wdata[0];

endmodule

// File: rtl/brk_addr_stage.sv
// Address-phase comparator of the break unit.
// Evaluates the masked address and the four qualifiers in the bus_start
// clock and holds the verdict and the fetch attribute until the cycle ends.
// Assumes cycles do not overlap; a zero-wait cycle bypasses the hold register.
module brk_addr_stage
    import brk_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_start,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_cpu,
    input  logic              bus_fetch,
    input  logic              bus_write,
    input  logic [1:0]        bus_size,
    input  logic [ADDR_W-1:0] acmp,
    input  logic [ADDR_W-1:0] amsk,
    input  qual_t             qual,
    output logic              sel_hit,
    output logic              sel_fetch
);

    localparam int NBIN = 3;

    logic [1:0]      codes [NBIN];
    logic            firsts[NBIN];
    logic [NBIN-1:0] bin_ok;
    logic            addr_ok, sz_ok, hit_now;
    logic            pend_hit, pend_fetch;

    // Route the two-option qualifiers to a common decoder.
    always_comb begin
        codes[0]  = qual.master;
        firsts[0] = bus_cpu;
        codes[1]  = qual.kind;
        firsts[1] = bus_fetch;
        codes[2]  = qual.dir;
        firsts[2] = !bus_write;
    end

    for (genvar g = 0; g < NBIN; g++) begin : g_bin
        assign bin_ok[g] = pair_ok(codes[g], firsts[g]);
    end

    // Masked address compare, size check and combined address-phase verdict.
    always_comb begin
        addr_ok = ((bus_addr ^ acmp) & ~amsk) == '0;
        sz_ok   = size_ok(qual.size, bus_size);
        hit_now = addr_ok && sz_ok && (&bin_ok);
    end

    // Hold the address-phase verdict for the rest of the cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_hit   <= 1'b0;
            pend_fetch <= 1'b0;
        end else if (bus_start) begin
            pend_hit   <= hit_now;
            pend_fetch <= bus_fetch;
        end
    end

    // Live verdict for a zero-wait cycle, held verdict otherwise.
    always_comb begin
        sel_hit   = bus_start ? hit_now   : pend_hit;
        sel_fetch = bus_start ? bus_fetch : pend_fetch;
    end

endmodule

// File: rtl/brk_data_stage.sv
// Completion-phase comparator and sticky status flag of the break unit.
// Compares data lane by lane for data accesses, combines with the
// address-phase verdict and sets the flag; a hit outranks a clear.
// Assumes DATA_W is a multiple of 8.
module brk_data_stage #(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_end,
    input  logic [DATA_W-1:0] bus_data,
    input  logic [DATA_W-1:0] dcmp,
    input  logic [DATA_W-1:0] dmsk,
    input  logic              sel_hit,
    input  logic              sel_fetch,
    input  logic              clr_req,
    output logic              hit_end,
    output logic              flag
);

    localparam int LANES = DATA_W / 8;

    logic [LANES-1:0] lane_ok;
    logic [DATA_W-1:0] diff;

    // Bits that differ and are not masked off.
    always_comb diff = (bus_data ^ dcmp) & ~dmsk;

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        assign lane_ok[l] = diff[l*8 +: 8] == 8'h00;
    end

    // Final match at completion; fetches skip the data check.
    always_comb hit_end = bus_end && sel_hit && (sel_fetch || (&lane_ok));

    // Sticky flag: set on a hit, cleared on request, hit wins.
    always_ff @(posedge clk) begin
        if (!rst_n)       flag <= 1'b0;
        else if (hit_end) flag <= 1'b1;
        else if (clr_req) flag <= 1'b0;
    end

endmodule

// File: rtl/bus_break_unit.sv
// Top of the bus-cycle break comparator.
// Wires the condition registers, the address-phase and completion-phase
// comparators, and gates the status flag into the interrupt request.
// Assumes one monitored cycle in flight at a time.
module bus_break_unit
    import brk_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    localparam int REG_W = (ADDR_W > DATA_W) ? ADDR_W : DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [CFG_AW-1:0] cfg_addr,
    input  logic [REG_W-1:0]  cfg_wdata,
    input  logic              bus_start,
    input  logic              bus_end,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_cpu,
    input  logic              bus_fetch,
    input  logic              bus_write,
    input  logic [1:0]        bus_size,
    input  logic [DATA_W-1:0] bus_data,
    output logic              brk_flag,
    output logic              brk_irq
);

    logic [ADDR_W-1:0] acmp, amsk;
    logic [DATA_W-1:0] dcmp, dmsk;
    qual_t             qual;
    logic              ien, clr_req;
    logic              sel_hit, sel_fetch, hit_end;

    brk_cfg_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .REG_W(REG_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .acmp(acmp), .amsk(amsk), .dcmp(dcmp),
        .dmsk(dmsk), .qual(qual), .ien(ien), .clr_req(clr_req)
    );

    brk_addr_stage #(.ADDR_W(ADDR_W)) u_addr (
        .clk(clk), .rst_n(rst_n), .bus_start(bus_start), .bus_addr(bus_addr),
        .bus_cpu(bus_cpu), .bus_fetch(bus_fetch), .bus_write(bus_write),
        .bus_size(bus_size), .acmp(acmp), .amsk(amsk), .qual(qual),
        .sel_hit(sel_hit), .sel_fetch(sel_fetch)
    );

    brk_data_stage #(.DATA_W(DATA_W)) u_data (
        .clk(clk), .rst_n(rst_n), .bus_end(bus_end), .bus_data(bus_data),
        .dcmp(dcmp), .dmsk(dmsk), .sel_hit(sel_hit), .sel_fetch(sel_fetch),
        .clr_req(clr_req), .hit_end(hit_end), .flag(brk_flag)
    );

    // Interrupt request follows the flag while enabled.
    always_comb brk_irq = brk_flag && ien;

endmodule

// File: rtl/brk_checker.sv
// Temporal checks on the break comparator, bound into the top module.
module brk_checker (
    input logic clk,
    input logic rst_n,
    input logic bus_end,
    input logic brk_flag,
    input logic brk_irq,
    input logic ien,
    input logic clr,
    input logic hit_end
);

    AST_FLAG_ONLY_AFTER_END: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(brk_flag) |-> $past(bus_end)); // R7

    AST_HIT_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        hit_end |=> brk_flag); // R7

    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (brk_flag && !clr) |=> brk_flag); // R8

    AST_CLEAR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && !hit_end) |=> !brk_flag); // R8

    AST_IRQ_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
        !ien |-> !brk_irq); // R9

    AST_IRQ_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        brk_irq |-> brk_flag); // R9

endmodule

bind bus_break_unit brk_checker u_chk (
    .clk(clk), .rst_n(rst_n), .bus_end(bus_end), .brk_flag(brk_flag),
    .brk_irq(brk_irq), .ien(ien), .clr(clr_req), .hit_end(hit_end)
);

// File: tb/bus_break_unit_test.sv
module bus_break_unit_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [2:0]  cfg_addr = '0;
    logic [31:0] cfg_wdata = '0;
    logic        bus_start = 1'b0, bus_end = 1'b0;
    logic [31:0] bus_addr = '0, bus_data = '0;
    logic        bus_cpu = 1'b0, bus_fetch = 1'b0, bus_write = 1'b0;
    logic [1:0]  bus_size = '0;
    logic        brk_flag, brk_irq;

    int checks = 0;
    int errors = 0;
    logic flag_at_end;

    always #2 clk = ~clk;

    bus_break_unit uut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .bus_start(bus_start), .bus_end(bus_end),
        .bus_addr(bus_addr), .bus_cpu(bus_cpu), .bus_fetch(bus_fetch),
        .bus_write(bus_write), .bus_size(bus_size), .bus_data(bus_data),
        .brk_flag(brk_flag), .brk_irq(brk_irq)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    // One monitored cycle; returns at the negedge after the completing edge.
    task automatic cyc(input logic cpu, input logic fe, input logic wrt, input logic [1:0] sz,
                       input logic [31:0] a, input logic [31:0] d, input int waits);
        @(negedge clk);
        bus_start = 1'b1; bus_addr = a; bus_cpu = cpu; bus_fetch = fe;
        bus_write = wrt; bus_size = sz;
        if (waits > 0) begin
            @(negedge clk);
            bus_start = 1'b0;
            // R11: scramble everything after the address phase
            bus_addr = ~a; bus_cpu = ~cpu; bus_fetch = ~fe; bus_write = ~wrt; bus_size = ~sz;
            repeat (waits - 1) @(negedge clk);
        end
        bus_end = 1'b1; bus_data = d; flag_at_end = brk_flag;
        @(negedge clk);
        bus_start = 1'b0; bus_end = 1'b0;
    endtask

    function automatic logic pick(input logic [1:0] code, input logic first);
        return (code == 2'd0) || (code == 2'd3) || (code == 2'd1 && first) || (code == 2'd2 && !first);
    endfunction

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin : main
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R10 flag after reset", {31'd0, brk_flag}, 32'd0);
        check("R10 irq after reset", {31'd0, brk_irq}, 32'd0);
        cyc(1'b1, 1'b0, 1'b0, 2'd2, 32'h0000_0001, 32'h0, 0);
        check("R10 nonzero address misses", {31'd0, brk_flag}, 32'd0);
        cyc(1'b1, 1'b0, 1'b0, 2'd2, 32'h0, 32'h0, 0);
        check("R10 zero cycle matches", {31'd0, brk_flag}, 32'd1);
        wr(3'd5, 32'd1);

        // Qualifier sweep with address and data don't-care
        wr(3'd1, 32'hFFFF_FFFF);
        wr(3'd3, 32'hFFFF_FFFF);
        for (int q = 0; q < 256; q++) begin
            wr(3'd4, 32'h100 | q);
            for (int v = 0; v < 24; v++) begin
                logic cpu, fe, wrt, exp;
                logic [1:0] sz;
                cpu = v[0]; fe = v[1]; wrt = v[2]; sz = 2'(v / 8);
                exp = pick(2'(q), cpu) && pick(2'(q >> 2), fe) && pick(2'(q >> 4), !wrt) &&
                      ((q >> 6) == 0 || ((q >> 6) - 1) == sz);
                cyc(cpu, fe, wrt, sz, 32'h1357_9BDF, 32'h0, v % 3);
                check("R2/R3/R4/R5/R11 qualifier sweep", {31'd0, brk_flag}, {31'd0, exp});
                check("R9 irq follows flag", {31'd0, brk_irq}, {31'd0, exp});
                wr(3'd5, 32'd1);
            end
        end

        // Address mask walk
        wr(3'd4, 32'h100);
        wr(3'd0, 32'hA5A5_0F0F);
        for (int i = 0; i < 32; i++) begin
            wr(3'd1, 32'd1 << i);
            cyc(1'b0, 1'b0, 1'b1, 2'd0, 32'hA5A5_0F0F ^ (32'd1 << i), 32'h0, 1);
            check("R1 masked bit ignored", {31'd0, brk_flag}, 32'd1);
            wr(3'd5, 32'd1);
            cyc(1'b0, 1'b0, 1'b1, 2'd0, 32'hA5A5_0F0F ^ (32'd1 << ((i + 1) % 32)), 32'h0, 1);
            check("R1 unmasked bit mismatch", {31'd0, brk_flag}, 32'd0);
        end

        // Data mask walk, data versus fetch
        wr(3'd1, 32'hFFFF_FFFF);
        wr(3'd2, 32'h3C3C_C3C3);
        for (int i = 0; i < 32; i++) begin
            wr(3'd3, 32'd1 << i);
            cyc(1'b1, 1'b0, 1'b0, 2'd1, 32'h10, 32'h3C3C_C3C3 ^ (32'd1 << i), 2);
            check("R6 masked data bit ignored", {31'd0, brk_flag}, 32'd1);
            wr(3'd5, 32'd1);
            cyc(1'b1, 1'b0, 1'b0, 2'd1, 32'h10, 32'h3C3C_C3C3 ^ (32'd1 << ((i + 1) % 32)), 2);
            check("R6 data mismatch rejects", {31'd0, brk_flag}, 32'd0);
            cyc(1'b1, 1'b1, 1'b0, 2'd1, 32'h10, 32'h3C3C_C3C3 ^ (32'd1 << ((i + 1) % 32)), 0);
            check("R6 fetch ignores data", {31'd0, brk_flag}, 32'd1);
            wr(3'd5, 32'd1);
        end

        // Timing of the flag
        wr(3'd3, 32'hFFFF_FFFF);
        cyc(1'b1, 1'b0, 1'b1, 2'd2, 32'h0, 32'h0, 0);
        check("R7 zero-wait flag low in end clock", {31'd0, flag_at_end}, 32'd0);
        check("R7 zero-wait flag next clock", {31'd0, brk_flag}, 32'd1);
        wr(3'd5, 32'd1);
        cyc(1'b1, 1'b0, 1'b1, 2'd2, 32'h0, 32'h0, 4);
        check("R7 waited flag low in end clock", {31'd0, flag_at_end}, 32'd0);
        check("R7 waited flag next clock", {31'd0, brk_flag}, 32'd1);

        // Stickiness and clear
        wr(3'd5, 32'd0);
        repeat (5) @(negedge clk);
        check("R8 write of zero keeps flag", {31'd0, brk_flag}, 32'd1);
        wr(3'd5, 32'd1);
        check("R8 write of one clears", {31'd0, brk_flag}, 32'd0);
        @(negedge clk);
        bus_start = 1'b1; bus_end = 1'b1; bus_addr = 32'h0; bus_data = 32'h0;
        bus_cpu = 1'b1; bus_fetch = 1'b0; bus_write = 1'b0; bus_size = 2'd2;
        cfg_we = 1'b1; cfg_addr = 3'd5; cfg_wdata = 32'd1;
        @(negedge clk);
        bus_start = 1'b0; bus_end = 1'b0; cfg_we = 1'b0;
        check("R8 hit beats clear", {31'd0, brk_flag}, 32'd1);

        // Enable gating
        wr(3'd4, 32'h000);
        check("R9 irq off when disabled", {31'd0, brk_irq}, 32'd0);
        check("R9 flag kept when disabling", {31'd0, brk_flag}, 32'd1);
        wr(3'd4, 32'h100);
        check("R9 irq on when enabled", {31'd0, brk_irq}, 32'd1);
        wr(3'd5, 32'd1);
        check("R9 irq drops with flag", {31'd0, brk_irq}, 32'd0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule